// File: doc/BRIEF.md
# Hierarchical Destination Route Lookup

This block turns the destination identifier of an arriving packet into the set of output ports that the packet must leave on. The answer is either a single port or a group of ports taken from a programmable mask. The lookup runs over two table levels. The upper byte of a wide identifier indexes a domain table. The lower byte indexes a device table. A two-bit transport-type input says whether the identifier is narrow (one byte) or wide (two bytes). A narrow identifier goes straight to the device table.

Every table entry is a one-byte routing code. One code range names a unicast port. A second range names one of the multicast mask registers. A dedicated code sends the packet to a programmable default port. In the domain table only, one more code redirects the lookup into the device table through the low byte. Entries that have never been written read as the default-port code.

There are several independent table sets, for example one for each ingress group. Each lookup names the set it uses. A programming access writes either one chosen set or all sets at once. Results leave through registered outputs two clock edges after the request is taken.

Top module: `hier_route_lookup`

## Requirements
- R1: `lk_tt` = 2'b00 selects a narrow identifier: only `lk_dest[7:0]` is used, through the device table, and `lk_dest[15:8]` has no effect. 2'b01 selects a wide identifier. 2'b10 and 2'b11 are reserved and give `rt_err`=1 with `rt_valid`=0.
- R2: For a wide identifier, the domain table is read at `lk_dest[15:8]`. Any entry other than 8'hDD is the final routing code.
- R3: A domain entry of 8'hDD makes the device-table entry at `lk_dest[7:0]` (same set) the final routing code.
- R4: A code from 8'h00 to 8'h0F gives `rt_valid`=1, and `rt_ports` has exactly bit n set, where n is the code value.
- R5: A code 8'h40+k, for k from 0 to 9, gives `rt_valid`=1 with `rt_ports` equal to mask register k. Bit n of a mask includes port n. An all-zero mask still yields `rt_valid`=1 with `rt_ports`=0.
- R6: After reset, every table entry reads as 8'hDE. Code 8'hDE routes to the default port, which resets to 0, as a one-hot `rt_ports`. All masks reset to zero.
- R7: A write is made with `cfg_we`=1, and `cfg_target` selects what it writes. 0 writes the domain entry at `cfg_addr`. 1 writes the device entry at `cfg_addr`. 2 writes mask register `cfg_addr` from `cfg_data`. 3 writes the default port from `cfg_data[3:0]`. For table writes, `cfg_all`=1 writes every set and `cfg_all`=0 writes set `cfg_set`, and the code is `cfg_data[7:0]`. A lookup reads only set `lk_set`.
- R8: Any other final code gives `rt_err`=1, `rt_valid`=0 and `rt_ports`=0. This covers 8'h10 to 8'h3F, 8'h4A and above (apart from 8'hDE), and 8'hDD found in the device table.
- R9: A request taken on a rising edge with `lk_valid`=1 produces its result on the second following rising edge, for one cycle. Without a request, `rt_valid` and `rt_err` stay 0.
- R10: A table write and a lookup of the same entry on the same edge return the entry's previous contents. The next lookup sees the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_tt | input | 2 | Transport type: 00 narrow, 01 wide, others reserved |
| lk_dest | input | 16 | Destination identifier |
| lk_set | input | 2 | Table set used by the lookup |
| cfg_we | input | 1 | Programming write strobe |
| cfg_target | input | 2 | 0 domain, 1 device, 2 mask, 3 default port |
| cfg_all | input | 1 | Write the table entry in every set |
| cfg_set | input | 2 | Set written when cfg_all is 0 |
| cfg_addr | input | 8 | Table index or mask number |
| cfg_data | input | 16 | Routing code (low byte), mask bits or default port |
| rt_valid | output | 1 | Lookup resolved to a port vector |
| rt_ports | output | 16 | Output port vector, bit n = port n |
| rt_err | output | 1 | Lookup hit a reserved type or an undefined code |

## Verification
The bench aims at the edges of the code ranges. These are the last unicast code, the last mask code and the first code past it, 8'hDD found in the device table, and an all-zero mask. A decoder with an off-by-one range would either send such packets to a wrong port or raise a spurious error. It also checks that a narrow lookup ignores the upper byte, that sets stay apart while broadcast writes reach all of them, and that a missing written-flag reset would turn a fresh table into garbage routes. A write-then-read ordering fault would show up in the same-edge collision test, as the new code arriving one lookup too early.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  localparam int unsigned CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_FORCE_LOCAL = 8'hDD;
  localparam logic [CODE_W-1:0] CODE_DEFAULT     = 8'hDE;
  localparam logic [CODE_W-1:0] CODE_MASK_BASE   = 8'h40;

  localparam logic [1:0] TGT_DOMAIN = 2'd0;
  localparam logic [1:0] TGT_DEVICE = 2'd1;
  localparam logic [1:0] TGT_MASK   = 2'd2;
  localparam logic [1:0] TGT_DFLT   = 2'd3;

  localparam logic [1:0] TT_NARROW = 2'b00;
  localparam logic [1:0] TT_WIDE   = 2'b01;
endpackage

// File: rtl/rlk_table_bank.sv
module rlk_table_bank import rlk_pkg::*; #(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dom,
  input  logic              wr_dev,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_dom_addr,
  input  logic [AW-1:0]     rd_dev_addr,
  output logic [CODE_W-1:0] dom_code,
  output logic [CODE_W-1:0] dev_code
);
  localparam int unsigned DEPTH = 1 << AW;

  // Plain arrays without reset so they map onto block RAM.
  logic [CODE_W-1:0] dom_mem [DEPTH];
  logic [CODE_W-1:0] dev_mem [DEPTH];
  logic [CODE_W-1:0] dom_raw, dev_raw;

  // Resettable per-entry written flags stand in for an init sweep.
  logic [DEPTH-1:0] dom_wr_flag, dev_wr_flag;
  logic             dom_hit, dev_hit;

  always_ff @(posedge clk) begin
    if (wr_dom) dom_mem[wr_addr] <= wr_code;
    if (rd_en)  dom_raw <= dom_mem[rd_dom_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_dev) dev_mem[wr_addr] <= wr_code;
    if (rd_en)  dev_raw <= dev_mem[rd_dev_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_wr_flag <= '0;
      dev_wr_flag <= '0;
      dom_hit     <= 1'b0;
      dev_hit     <= 1'b0;
    end else begin
      if (wr_dom) dom_wr_flag[wr_addr] <= 1'b1;
      if (wr_dev) dev_wr_flag[wr_addr] <= 1'b1;
      if (rd_en) begin
        dom_hit <= dom_wr_flag[rd_dom_addr];
        dev_hit <= dev_wr_flag[rd_dev_addr];
      end
    end
  end

  assign dom_code = dom_hit ? dom_raw : CODE_DEFAULT;
  assign dev_code = dev_hit ? dev_raw : CODE_DEFAULT;

  // R6: an entry never written since reset reads back as the default code
  p_fresh_dom_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !dom_wr_flag[rd_dom_addr]) |=> (dom_code == CODE_DEFAULT));
  p_fresh_dev_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !dev_wr_flag[rd_dev_addr]) |=> (dev_code == CODE_DEFAULT));
endmodule

// File: rtl/rlk_mask_regs.sv
module rlk_mask_regs #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned NUM_MASKS = 10,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PORT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mask_we,
  input  logic                 dflt_we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [NUM_PORTS-1:0] wdata,
  output logic [NUM_PORTS-1:0] masks [NUM_MASKS],
  output logic [PORT_W-1:0]    dflt_port
);
  for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                                  masks[k] <= '0;
      else if (mask_we && idx == IDX_W'(k))     masks[k] <= wdata;
    end

    // R7: a mask write lands in exactly the addressed register
    p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
      (mask_we && idx == IDX_W'(k)) |=> (masks[k] == $past(wdata)));
  end

  always_ff @(posedge clk) begin
    if (rst)          dflt_port <= '0;
    else if (dflt_we) dflt_port <= wdata[PORT_W-1:0];
  end

  // R7: default port follows its write
  p_dflt_load_r7: assert property (@(posedge clk) disable iff (rst)
    dflt_we |=> (dflt_port == $past(wdata[PORT_W-1:0])));
endmodule

// File: rtl/rlk_code_decode.sv
module rlk_code_decode import rlk_pkg::*; #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned NUM_MASKS = 10,
  parameter int unsigned PORT_W    = 4
) (
  input  logic [CODE_W-1:0]    code,
  input  logic [NUM_PORTS-1:0] masks [NUM_MASKS],
  input  logic [PORT_W-1:0]    dflt_port,
  output logic [NUM_PORTS-1:0] vec,
  output logic                 ok
);
  always_comb begin
    vec = '0;
    ok  = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (code == CODE_W'(p)) begin
        vec[p] = 1'b1;
        ok     = 1'b1;
      end
    end
    for (int k = 0; k < NUM_MASKS; k++) begin
      if (code == CODE_MASK_BASE + CODE_W'(k)) begin
        vec = masks[k];
        ok  = 1'b1;
      end
    end
    if (code == CODE_DEFAULT) begin
      ok = 1'b1;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (dflt_port == PORT_W'(p)) vec[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hier_route_lookup.sv
module hier_route_lookup import rlk_pkg::*; #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned NUM_MASKS = 10,
  parameter int unsigned NUM_SETS  = 4,
  parameter int unsigned ID_W      = 16
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    lk_valid,
  input  logic [1:0]                              lk_tt,
  input  logic [ID_W-1:0]                         lk_dest,
  input  logic [((NUM_SETS > 1) ? $clog2(NUM_SETS) : 1)-1:0] lk_set,
  input  logic                                    cfg_we,
  input  logic [1:0]                              cfg_target,
  input  logic                                    cfg_all,
  input  logic [((NUM_SETS > 1) ? $clog2(NUM_SETS) : 1)-1:0] cfg_set,
  input  logic [ID_W/2-1:0]                       cfg_addr,
  input  logic [NUM_PORTS-1:0]                    cfg_data,
  output logic                                    rt_valid,
  output logic [NUM_PORTS-1:0]                    rt_ports,
  output logic                                    rt_err
);
  localparam int unsigned HALF_W = ID_W / 2;
  localparam int unsigned SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int unsigned PORT_W = $clog2(NUM_PORTS);

  // ---------------- programming decode ----------------
  logic wr_dom_any, wr_dev_any, wr_mask, wr_dflt;
  assign wr_dom_any = cfg_we && (cfg_target == TGT_DOMAIN);
  assign wr_dev_any = cfg_we && (cfg_target == TGT_DEVICE);
  assign wr_mask    = cfg_we && (cfg_target == TGT_MASK);
  assign wr_dflt    = cfg_we && (cfg_target == TGT_DFLT);

  // ---------------- table sets ----------------
  logic [CODE_W-1:0] dom_codes [NUM_SETS];
  logic [CODE_W-1:0] dev_codes [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel;
    assign sel = cfg_all || (cfg_set == SET_W'(s));

    rlk_table_bank #(.AW(HALF_W)) bank_i (
      .clk         (clk),
      .rst         (rst),
      .wr_dom      (wr_dom_any && sel),
      .wr_dev      (wr_dev_any && sel),
      .wr_addr     (cfg_addr),
      .wr_code     (cfg_data[CODE_W-1:0]),
      .rd_en       (lk_valid),
      .rd_dom_addr (lk_dest[ID_W-1:HALF_W]),
      .rd_dev_addr (lk_dest[HALF_W-1:0]),
      .dom_code    (dom_codes[s]),
      .dev_code    (dev_codes[s])
    );
  end

  // ---------------- masks and default port ----------------
  logic [NUM_PORTS-1:0] masks [NUM_MASKS];
  logic [PORT_W-1:0]    dflt_port;

  rlk_mask_regs #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_MASKS (NUM_MASKS),
    .IDX_W     (HALF_W),
    .PORT_W    (PORT_W)
  ) mask_i (
    .clk       (clk),
    .rst       (rst),
    .mask_we   (wr_mask),
    .dflt_we   (wr_dflt),
    .idx       (cfg_addr),
    .wdata     (cfg_data),
    .masks     (masks),
    .dflt_port (dflt_port)
  );

  // ---------------- stage 1: request tags alongside table reads ----------------
  logic             s1_valid, s1_wide, s1_bad_tt;
  logic [SET_W-1:0] s1_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_wide   <= 1'b0;
      s1_bad_tt <= 1'b0;
      s1_set    <= '0;
    end else begin
      s1_valid  <= lk_valid;
      s1_wide   <= (lk_tt == TT_WIDE);
      s1_bad_tt <= lk_tt[1];
      s1_set    <= lk_set;
    end
  end

  // ---------------- stage 2: pick level, decode, register ----------------
  logic [CODE_W-1:0]    dom_c, dev_c, final_code;
  logic [NUM_PORTS-1:0] dec_vec;
  logic                 dec_ok, good;

  assign dom_c      = dom_codes[s1_set];
  assign dev_c      = dev_codes[s1_set];
  assign final_code = (s1_wide && (dom_c != CODE_FORCE_LOCAL)) ? dom_c : dev_c;

  rlk_code_decode #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_MASKS (NUM_MASKS),
    .PORT_W    (PORT_W)
  ) dec_i (
    .code      (final_code),
    .masks     (masks),
    .dflt_port (dflt_port),
    .vec       (dec_vec),
    .ok        (dec_ok)
  );

  assign good = s1_valid && !s1_bad_tt && dec_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_valid <= 1'b0;
      rt_err   <= 1'b0;
      rt_ports <= '0;
    end else begin
      rt_valid <= good;
      rt_err   <= s1_valid && !good;
      rt_ports <= good ? dec_vec : '0;
    end
  end

  // R8: error and valid never coincide, and an error carries no ports
  p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(rt_valid && rt_err));
  p_err_noports_r8: assert property (@(posedge clk) disable iff (rst)
    rt_err |-> (rt_ports == '0));
  // R9: any result traces back to a request two edges earlier
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (rt_valid || rt_err) |-> $past(lk_valid, 2));
  // R1: reserved transport types always end in an error
  p_badtt_r1: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_tt[1]) |-> ##2 (rt_err && !rt_valid));
  // R4: a unicast code yields exactly one port
  p_unicast_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_bad_tt && final_code < CODE_W'(NUM_PORTS))
      |=> (rt_valid && $countones(rt_ports) == 1));
endmodule

// File: tb/hier_route_lookup_tb_top.sv
`timescale 1ns/1ps
module hier_route_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_tt = 2'b00;
  logic [15:0] lk_dest = '0;
  logic [1:0]  lk_set = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_target = '0;
  logic        cfg_all = 1'b0;
  logic [1:0]  cfg_set = '0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        rt_valid, rt_err;
  logic [15:0] rt_ports;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hier_route_lookup dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_tt(lk_tt), .lk_dest(lk_dest),
    .lk_set(lk_set), .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_all(cfg_all),
    .cfg_set(cfg_set), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rt_valid(rt_valid), .rt_ports(rt_ports), .rt_err(rt_err)
  );

  // {tt, dest, set, exp_valid, exp_err, exp_ports}
  localparam int NV = 22;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 16'h0010, 2'd0, 1'b1, 1'b0, 16'h0008}, // R4 unicast 3
    {2'd0, 16'hFF10, 2'd0, 1'b1, 1'b0, 16'h0008}, // R1 upper byte ignored
    {2'd0, 16'h0020, 2'd1, 1'b1, 1'b0, 16'h0F00}, // R5 last mask
    {2'd0, 16'h0021, 2'd0, 1'b1, 1'b0, 16'h8421}, // R5 mask 0
    {2'd0, 16'h0033, 2'd3, 1'b1, 1'b0, 16'h8000}, // R4 last port
    {2'd0, 16'h0030, 2'd0, 1'b0, 1'b1, 16'h0000}, // R8 code 0x10
    {2'd0, 16'h0031, 2'd0, 1'b0, 1'b1, 16'h0000}, // R8 0xDD in device table
    {2'd0, 16'h0034, 2'd0, 1'b0, 1'b1, 16'h0000}, // R8 code 0x4A
    {2'd0, 16'h0032, 2'd0, 1'b1, 1'b0, 16'h0000}, // R5 empty mask
    {2'd0, 16'h0055, 2'd0, 1'b1, 1'b0, 16'h0020}, // R6 default port 5
    {2'd1, 16'h0110, 2'd0, 1'b1, 1'b0, 16'h0008}, // R3 force local
    {2'd1, 16'h0120, 2'd0, 1'b1, 1'b0, 16'h0F00}, // R3 force local to mask
    {2'd1, 16'h0210, 2'd0, 1'b1, 1'b0, 16'h0080}, // R2 domain unicast 7
    {2'd1, 16'h0310, 2'd0, 1'b1, 1'b0, 16'h00F0}, // R2 domain mask 1
    {2'd1, 16'h0410, 2'd0, 1'b0, 1'b1, 16'h0000}, // R8 domain code 0x50
    {2'd1, 16'h0510, 2'd0, 1'b1, 1'b0, 16'h0020}, // R6 fresh domain entry
    {2'd0, 16'h0010, 2'd2, 1'b1, 1'b0, 16'h1000}, // R7 per-set override
    {2'd1, 16'h0210, 2'd2, 1'b1, 1'b0, 16'h1000}, // R7 set 2 domain -> device
    {2'd1, 16'h0210, 2'd1, 1'b1, 1'b0, 16'h0080}, // R7 other set untouched
    {2'd2, 16'h0010, 2'd0, 1'b0, 1'b1, 16'h0000}, // R1 reserved tt
    {2'd3, 16'h0010, 2'd0, 1'b0, 1'b1, 16'h0000}, // R1 reserved tt
    {2'd0, 16'h0055, 2'd1, 1'b1, 1'b0, 16'h0020}  // R6 default in set 1
  };

  task automatic check(input string req, input logic v, input logic e, input logic [15:0] p,
                       input logic ev, input logic ee, input logic [15:0] ep);
    checks++;
    if (v !== ev || e !== ee || p !== ep) begin
      fails++;
      $display("FAIL %s: got valid=%0b err=%0b ports=%h, expected valid=%0b err=%0b ports=%h",
               req, v, e, p, ev, ee, ep);
    end
  endtask

  task automatic cfg_write(input logic [1:0] tgt, input logic all, input logic [1:0] set,
                           input logic [7:0] addr, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_target = tgt; cfg_all = all; cfg_set = set;
    cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [1:0] tt, input logic [15:0] dest, input logic [1:0] set);
    @(negedge clk);
    lk_valid = 1'b1; lk_tt = tt; lk_dest = dest; lk_set = set;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset state", rt_valid, rt_err, rt_ports, 1'b0, 1'b0, 16'h0000);

    lookup(2'd0, 16'h0012, 2'd0);
    check("R6 fresh table, default port 0", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0001);

    // programming (R7)
    cfg_write(2'd3, 1'b0, 2'd0, 8'h00, 16'h0005);
    cfg_write(2'd2, 1'b0, 2'd0, 8'h00, 16'h8421);
    cfg_write(2'd2, 1'b0, 2'd0, 8'h01, 16'h00F0);
    cfg_write(2'd2, 1'b0, 2'd0, 8'h09, 16'h0F00);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h10, 16'h0003);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h20, 16'h0049);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h21, 16'h0040);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h30, 16'h0010);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h31, 16'h00DD);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h32, 16'h0043);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h33, 16'h000F);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h34, 16'h004A);
    cfg_write(2'd0, 1'b1, 2'd0, 8'h01, 16'h00DD);
    cfg_write(2'd0, 1'b1, 2'd0, 8'h02, 16'h0007);
    cfg_write(2'd0, 1'b1, 2'd0, 8'h03, 16'h0041);
    cfg_write(2'd0, 1'b1, 2'd0, 8'h04, 16'h0050);
    cfg_write(2'd1, 1'b0, 2'd2, 8'h10, 16'h000C);
    cfg_write(2'd0, 1'b0, 2'd2, 8'h02, 16'h00DD);

    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][37:36], VEC[i][35:20], VEC[i][19:18]);
      check($sformatf("vector %0d", i), rt_valid, rt_err, rt_ports,
            VEC[i][17], VEC[i][16], VEC[i][15:0]);
    end

    // R9: nothing yet one edge after the request, result on the second
    @(negedge clk);
    lk_valid = 1'b1; lk_tt = 2'd0; lk_dest = 16'h0010; lk_set = 2'd0;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9 not before second edge", rt_valid, rt_err, rt_ports, 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    check("R9 result on second edge", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0008);
    @(negedge clk);
    check("R9 single-cycle result", rt_valid, rt_err, rt_ports, 1'b0, 1'b0, 16'h0000);

    // R10: same-edge write and lookup sees the old entry
    @(negedge clk);
    cfg_we = 1'b1; cfg_target = 2'd1; cfg_all = 1'b0; cfg_set = 2'd0;
    cfg_addr = 8'h60; cfg_data = 16'h0002;
    lk_valid = 1'b1; lk_tt = 2'd0; lk_dest = 16'h0060; lk_set = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    check("R10 collision returns old entry", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0020);
    lookup(2'd0, 16'h0060, 2'd0);
    check("R10 next lookup sees new entry", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0004);
    lookup(2'd0, 16'h0060, 2'd1);
    check("R7 single-set write stays in its set", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0020);

    // R6: reset clears tables, masks and default port
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    lookup(2'd0, 16'h0010, 2'd0);
    check("R6 device table cleared by reset", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0001);
    lookup(2'd1, 16'h0210, 2'd0);
    check("R6 domain table cleared by reset", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0001);
    cfg_write(2'd1, 1'b1, 2'd0, 8'h21, 16'h0040);
    lookup(2'd0, 16'h0021, 2'd3);
    check("R6 mask 0 cleared by reset", rt_valid, rt_err, rt_ports, 1'b1, 1'b0, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule